// File: doc/BRIEF.md
# Multi-Cycle Integer Multiply-Accumulate Unit with Long Results

This block multiplies two 32-bit integers over several clock cycles. In short mode it returns the low word of the product, with the option of adding one 32-bit accumulator word. In long mode it returns the full 64-bit product. That product is signed or unsigned as the caller selects, and the caller can add a 64-bit accumulator built from two words.

A start pulse captures the operands, the mode bits, the incoming condition flags and the register numbers of the instruction. Before any work begins, the block checks those register numbers for legality. A legal operation sets `busy`. Its latency depends on the magnitude of the multiplier operand, plus one cycle for accumulate and one more for long mode. At the end, `done` pulses for one cycle and the results and flags update. An illegal operation is refused at once with a one-cycle `done` and `illegal` pulse.

Top module: `mac_long_unit`

## Requirements
- R1: In short mode (`long_mode`=0), `res_lo` is the low 32 bits of `op_a*op_b`, plus `acc_lo` (modulo 2^32) when `acc_en`=1; `res_hi` is 0.
- R2: In long mode, {`res_hi`,`res_lo`} is the 64-bit product. Both operands are two's complement when `sign_mode`=1 and unsigned when it is 0.
- R3: In long mode with `acc_en`=1, the 64-bit value {`acc_hi`,`acc_lo`} is added to the product modulo 2^64.
- R4: The array cycle count is 1 if `op_b[31:8]` are all zeros or all ones. Otherwise it is 2 if `op_b[31:16]` are, 3 if `op_b[31:24]` are, and 4 in every other case.
- R5: A legal operation has latency L = array cycles + `acc_en` + `long_mode`. Its `done` appears after the L-th rising edge that follows the start edge, and `lat_cycles` shows L from the edge after the start until the next accepted operation.
- R6: `done` is high for exactly one cycle per accepted operation. `busy` is high from the edge after an accepted legal start until `done` rises.
- R7: An operation is illegal in either of two cases. The first is that any checked register number equals 15. In short mode the checked numbers are `idx_dst`, `idx_acc`, `idx_mul_a` and `idx_mul_b`. In long mode they are `idx_dst`, `idx_dst_lo`, `idx_mul_a` and `idx_mul_b`. The second is that, in short mode, `idx_dst` equals `idx_mul_a`. An illegal operation raises `done` and `illegal` together on the start edge. `res_lo`, `res_hi` and `flags_out` keep their values, and `lat_cycles` becomes 0.
- R8: With `set_flags`=1, `flags_out` is {N,Z,C,V} in bits [3:0]. N is bit 31 (short) or bit 63 (long) of the result. Z is 1 when the whole result is zero. C and V are 0.
- R9: With `set_flags`=0, `flags_out` takes the `flags_in` value captured at start.
- R10: A `start` while `busy` is high is ignored: it does not change the results, the latency or the operand values in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier (sets array cycle count) |
| acc_lo | input | 32 | Accumulator low word |
| acc_hi | input | 32 | Accumulator high word (long mode) |
| long_mode | input | 1 | 1 = 64-bit result |
| sign_mode | input | 1 | 1 = signed long product |
| acc_en | input | 1 | 1 = accumulate |
| set_flags | input | 1 | 1 = compute new flags |
| flags_in | input | 4 | Current {N,Z,C,V} |
| idx_dst | input | 4 | Destination (short) / high destination (long) register number |
| idx_dst_lo | input | 4 | Low destination register number (long) |
| idx_acc | input | 4 | Accumulator register number (short) |
| idx_mul_a | input | 4 | Register number of op_a |
| idx_mul_b | input | 4 | Register number of op_b |
| res_lo | output | 32 | Result low word |
| res_hi | output | 32 | Result high word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| lat_cycles | output | 3 | Latency of the last accepted operation |
| flags_out | output | 4 | Updated {N,Z,C,V} |
| illegal | output | 1 | Illegal-operation pulse, with done |

## Verification
The latency of a legal operation is L = array cycles + accumulate + long. Its results and flags are due after the L-th edge that follows the start edge. An illegal operation is due on the start edge itself. The bench drives inputs on the falling edge and then counts falling edges until `done` is seen. It requires that count to equal L, or 0 for an illegal operation, and it reads the results in that same half-cycle. While an operation is busy, the bench sends a second start with a changed operand and expects the first operation's result and latency.

// File: rtl/mac_long_pkg.sv
package mac_long_pkg;
   typedef enum logic [1:0] {
      FLG_V = 2'd0,
      FLG_C = 2'd1,
      FLG_Z = 2'd2,
      FLG_N = 2'd3
   } flag_pos_e;

   typedef struct packed {
      logic long_m;
      logic sign_m;
      logic acc_m;
      logic setf_m;
   } mac_mode_t;
endpackage

// File: rtl/mac_array_depth.sv
module mac_array_depth #(
   parameter int WIDTH  = 32,
   parameter int STEP_W = 8,
   localparam int NGRP  = WIDTH / STEP_W,
   localparam int CNT_W = $clog2(NGRP + 1)
) (
   input  logic [WIDTH-1:0] mult_b,
   output logic [CNT_W-1:0] depth
);
   logic [NGRP-1:0] upper_same;

   assign upper_same[0] = 1'b0;
   for (genvar g = 1; g < NGRP; g++) begin : g_grp
      assign upper_same[g] = (&mult_b[WIDTH-1:g*STEP_W]) | ~(|mult_b[WIDTH-1:g*STEP_W]);
   end

   always_comb begin
      depth = CNT_W'(NGRP);
      for (int g = NGRP - 1; g >= 1; g--) begin
         if (upper_same[g]) depth = CNT_W'(g);
      end
   end
endmodule

// File: rtl/mac_legality.sv
module mac_legality #(
   parameter int IDX_W  = 4,
   parameter int PC_IDX = 15
) (
   input  logic             long_m,
   input  logic [IDX_W-1:0] i_dst,
   input  logic [IDX_W-1:0] i_dst_lo,
   input  logic [IDX_W-1:0] i_acc,
   input  logic [IDX_W-1:0] i_ma,
   input  logic [IDX_W-1:0] i_mb,
   output logic             bad
);
   localparam logic [IDX_W-1:0] PCV = IDX_W'(PC_IDX);
   logic pc_common, pc_mode, overlap;

   always_comb begin
      pc_common = (i_dst == PCV) || (i_ma == PCV) || (i_mb == PCV);
      pc_mode   = long_m ? (i_dst_lo == PCV) : (i_acc == PCV);
      overlap   = !long_m && (i_dst == i_ma);
      bad       = pc_common || pc_mode || overlap;
   end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
   import mac_long_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  mac_mode_t        mode,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [WIDTH-1:0] acc_l,
   input  logic [WIDTH-1:0] acc_h,
   output logic [WIDTH-1:0] r_lo,
   output logic [WIDTH-1:0] r_hi,
   output logic [3:0]       nzcv
);
   localparam int DW = 2 * WIDTH;
   logic [DW-1:0] ext_a, ext_b, prod, acc_v, sum;
   logic          sx;

   always_comb begin
      sx    = mode.long_m && mode.sign_m;
      ext_a = {{WIDTH{sx & a[WIDTH-1]}}, a};
      ext_b = {{WIDTH{sx & b[WIDTH-1]}}, b};
      prod  = ext_a * ext_b;
      acc_v = '0;
      if (mode.acc_m) acc_v = mode.long_m ? {acc_h, acc_l} : {{WIDTH{1'b0}}, acc_l};
      sum   = prod + acc_v;
      r_lo  = sum[WIDTH-1:0];
      r_hi  = mode.long_m ? sum[DW-1:WIDTH] : '0;
      nzcv  = '0;
      nzcv[FLG_N] = mode.long_m ? sum[DW-1] : sum[WIDTH-1];
      nzcv[FLG_Z] = mode.long_m ? (sum == '0) : (sum[WIDTH-1:0] == '0);
   end
endmodule

// File: rtl/mac_long_unit.sv
module mac_long_unit
   import mac_long_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter int STEP_W = 8,
   parameter int IDX_W  = 4,
   parameter int PC_IDX = 15,
   localparam int NGRP  = WIDTH / STEP_W,
   localparam int MAXL  = NGRP + 2,
   localparam int LAT_W = $clog2(MAXL + 1),
   localparam int DEP_W = $clog2(NGRP + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [WIDTH-1:0] acc_lo,
   input  logic [WIDTH-1:0] acc_hi,
   input  logic             long_mode,
   input  logic             sign_mode,
   input  logic             acc_en,
   input  logic             set_flags,
   input  logic [3:0]       flags_in,
   input  logic [IDX_W-1:0] idx_dst,
   input  logic [IDX_W-1:0] idx_dst_lo,
   input  logic [IDX_W-1:0] idx_acc,
   input  logic [IDX_W-1:0] idx_mul_a,
   input  logic [IDX_W-1:0] idx_mul_b,
   output logic [WIDTH-1:0] res_lo,
   output logic [WIDTH-1:0] res_hi,
   output logic             busy,
   output logic             done,
   output logic [LAT_W-1:0] lat_cycles,
   output logic [3:0]       flags_out,
   output logic             illegal
);
   if (WIDTH % STEP_W != 0) begin : g_chk_div
      $error("WIDTH must be a multiple of STEP_W");
   end
   if (NGRP < 2) begin : g_chk_grp
      $error("need at least two multiplier groups");
   end
   if (PC_IDX >= (1 << IDX_W)) begin : g_chk_pc
      $error("PC_IDX does not fit IDX_W");
   end

   logic [DEP_W-1:0] dep_now;
   logic             bad_now;
   logic [LAT_W-1:0] lat_now;
   mac_mode_t        mode_q;
   logic [WIDTH-1:0] a_q, b_q, al_q, ah_q;
   logic [3:0]       fin_q;
   logic [LAT_W-1:0] cnt_q;
   logic [WIDTH-1:0] dp_lo, dp_hi;
   logic [3:0]       dp_f;
   logic             accept;

   mac_array_depth #(.WIDTH(WIDTH), .STEP_W(STEP_W)) u_depth (
      .mult_b (op_b),
      .depth  (dep_now)
   );

   mac_legality #(.IDX_W(IDX_W), .PC_IDX(PC_IDX)) u_legal (
      .long_m   (long_mode),
      .i_dst    (idx_dst),
      .i_dst_lo (idx_dst_lo),
      .i_acc    (idx_acc),
      .i_ma     (idx_mul_a),
      .i_mb     (idx_mul_b),
      .bad      (bad_now)
   );

   mac_datapath #(.WIDTH(WIDTH)) u_dp (
      .mode  (mode_q),
      .a     (a_q),
      .b     (b_q),
      .acc_l (al_q),
      .acc_h (ah_q),
      .r_lo  (dp_lo),
      .r_hi  (dp_hi),
      .nzcv  (dp_f)
   );

   assign lat_now = LAT_W'(dep_now) + LAT_W'(acc_en) + LAT_W'(long_mode);
   assign accept  = start && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= '0;
         a_q        <= '0;
         b_q        <= '0;
         al_q       <= '0;
         ah_q       <= '0;
         fin_q      <= '0;
         cnt_q      <= '0;
         busy       <= 1'b0;
         done       <= 1'b0;
         illegal    <= 1'b0;
         lat_cycles <= '0;
         res_lo     <= '0;
         res_hi     <= '0;
         flags_out  <= '0;
      end else begin
         done    <= 1'b0;
         illegal <= 1'b0;
         if (busy) begin
            if (cnt_q == LAT_W'(1)) begin
               busy      <= 1'b0;
               done      <= 1'b1;
               res_lo    <= dp_lo;
               res_hi    <= dp_hi;
               flags_out <= mode_q.setf_m ? dp_f : fin_q;
            end else begin
               cnt_q <= cnt_q - LAT_W'(1);
            end
         end else if (accept) begin
            if (bad_now) begin
               done       <= 1'b1;
               illegal    <= 1'b1;
               lat_cycles <= '0;
            end else begin
               busy       <= 1'b1;
               cnt_q      <= lat_now;
               lat_cycles <= lat_now;
               mode_q     <= '{long_m: long_mode, sign_m: sign_mode,
                               acc_m: acc_en, setf_m: set_flags};
               a_q        <= op_a;
               b_q        <= op_b;
               al_q       <= acc_lo;
               ah_q       <= acc_hi;
               fin_q      <= flags_in;
            end
         end
      end
   end
endmodule

// File: rtl/mac_long_chk.sv
module mac_long_chk #(
   parameter int WIDTH = 32,
   parameter int LAT_W = 3,
   parameter int MAXL  = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic             illegal,
   input logic [LAT_W-1:0] lat_cycles,
   input logic [WIDTH-1:0] res_lo,
   input logic [WIDTH-1:0] res_hi
);
   logic [LAT_W:0] busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_run <= '0;
      else if (busy) busy_run <= busy_run + 1'b1;
      else busy_run <= '0;
   end

   assert_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> busy || (done && illegal));
   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   assert_illegal_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> done);
   assert_hold_results_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !done || illegal |-> $stable(res_lo) && $stable(res_hi));
   assert_lat_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> lat_cycles >= LAT_W'(1) && lat_cycles <= LAT_W'(MAXL));
   assert_busy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run <= (LAT_W+1)'(MAXL));
   assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy && start |=> $stable(lat_cycles));
endmodule

bind mac_long_unit mac_long_chk #(.WIDTH(WIDTH), .LAT_W(LAT_W), .MAXL(MAXL)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .busy       (busy),
   .done       (done),
   .illegal    (illegal),
   .lat_cycles (lat_cycles),
   .res_lo     (res_lo),
   .res_hi     (res_hi)
);

// File: tb/sim_mac_long_unit.sv
module sim_mac_long_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] op_a = '0, op_b = '0, acc_lo = '0, acc_hi = '0;
   logic        long_mode = 1'b0, sign_mode = 1'b0, acc_en = 1'b0, set_flags = 1'b0;
   logic [3:0]  flags_in = '0;
   logic [3:0]  idx_dst = 4'd1, idx_dst_lo = 4'd2, idx_acc = 4'd3, idx_mul_a = 4'd4, idx_mul_b = 4'd5;
   logic [31:0] res_lo, res_hi;
   logic        busy, done, illegal;
   logic [2:0]  lat_cycles;
   logic [3:0]  flags_out;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   logic [31:0] prev_lo = '0, prev_hi = '0;
   logic [3:0]  prev_f = '0;

   always #10 clk = ~clk;

   mac_long_unit u0 (.*);

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         total++;
         bad++;
         $display("FAIL watchdog: act=%0d exp=<150000", cyc);
         finish_run();
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
      end
   endtask

   function automatic int depth_of(input logic [31:0] b);
      if (&b[31:8] || ~|b[31:8]) return 1;
      if (&b[31:16] || ~|b[31:16]) return 2;
      if (&b[31:24] || ~|b[31:24]) return 3;
      return 4;
   endfunction

   function automatic bit is_bad();
      if (idx_dst == 15 || idx_mul_a == 15 || idx_mul_b == 15) return 1;
      if (long_mode) return idx_dst_lo == 15;
      return (idx_acc == 15) || (idx_dst == idx_mul_a);
   endfunction

   function automatic logic [63:0] model();
      logic [63:0] p;
      if (long_mode && sign_mode) p = 64'($signed({{32{op_a[31]}}, op_a}) * $signed({{32{op_b[31]}}, op_b}));
      else p = {32'b0, op_a} * {32'b0, op_b};
      if (long_mode) begin
         if (acc_en) p = p + {acc_hi, acc_lo};
      end else begin
         p = {32'b0, p[31:0] + (acc_en ? acc_lo : 32'b0)};
      end
      return p;
   endfunction

   task automatic go(input bit poke);
      bit          ill = is_bad();
      logic [63:0] exp_r = model();
      int          exp_l = depth_of(op_b) + int'(acc_en) + int'(long_mode);
      logic [3:0]  exp_f;
      int          n = 0;
      string       rq = long_mode ? (acc_en ? "R3" : "R2") : "R1";
      if (set_flags) exp_f = {long_mode ? exp_r[63] : exp_r[31], exp_r == 64'd0, 2'b00};
      else exp_f = flags_in;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && n < 20) begin
         @(negedge clk);
         n++;
         if (poke && n == 1 && !done) begin
            start = 1'b1;
            op_a = ~op_a;
         end else begin
            start = 1'b0;
         end
      end
      start = 1'b0;
      if (ill) begin
         chk(illegal === 1'b1 && n == 0, "R7", "illegal pulse/timing", {31'b0, illegal, 32'(n)}, {32'd1, 32'd0});
         chk({res_hi, res_lo} === {prev_hi, prev_lo}, "R7", "result hold", {res_hi, res_lo}, {prev_hi, prev_lo});
         chk(flags_out === prev_f && lat_cycles == 0, "R7", "flags hold/lat", {flags_out, 1'b0, lat_cycles}, {prev_f, 4'b0});
      end else begin
         chk(n == exp_l && illegal === 1'b0, "R5", "done latency", 64'(n), 64'(exp_l));
         chk(lat_cycles == 3'(exp_l), "R4", "lat_cycles", 64'(lat_cycles), 64'(exp_l));
         chk({res_hi, res_lo} === exp_r, poke ? "R10" : rq, "result", {res_hi, res_lo}, exp_r);
         chk(flags_out === exp_f, set_flags ? "R8" : "R9", "flags", 64'(flags_out), 64'(exp_f));
         prev_lo = res_lo;
         prev_hi = res_hi;
         prev_f  = flags_out;
      end
      @(negedge clk);
      chk(done === 1'b0 && busy === 1'b0, "R6", "single done pulse", {62'b0, done, busy}, 64'd0);
   endtask

   task automatic setop(input logic [31:0] a, b, al, ah, input bit lm, sm, ae, sf);
      op_a = a; op_b = b; acc_lo = al; acc_hi = ah;
      long_mode = lm; sign_mode = sm; acc_en = ae; set_flags = sf;
   endtask

   initial begin
      void'($urandom(1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy === 0 && done === 0 && res_lo === 0 && res_hi === 0 && flags_out === 0 && lat_cycles === 0,
          "R6", "reset state", {res_hi, res_lo}, 64'd0);

      // directed: R4 depth groups
      setop(32'd7, 32'd0, 0, 0, 0, 0, 0, 1); go(0);
      setop(32'd7, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 1); go(0);
      setop(32'd3, 32'h0000_0100, 0, 0, 0, 0, 0, 0); flags_in = 4'b1011; go(0);
      setop(32'd3, 32'hFFFF_0000, 0, 0, 0, 0, 1, 1); go(0);
      setop(32'd5, 32'h00FF_0000, 32'd9, 0, 0, 0, 1, 1); go(0);
      setop(32'd5, 32'h7F00_0000, 0, 0, 1, 0, 1, 1); go(0);
      // R2 signed vs unsigned long
      setop(32'hFFFF_FFFE, 32'd3, 0, 0, 1, 1, 0, 1); go(0);
      setop(32'hFFFF_FFFE, 32'd3, 0, 0, 1, 0, 0, 1); go(0);
      setop(32'h8000_0000, 32'h8000_0000, 0, 0, 1, 1, 0, 1); go(0);
      // R3 carry across words, R8 zero in long
      setop(32'hFFFF_FFFF, 32'd1, 32'd1, 32'hFFFF_FFFF, 1, 0, 1, 1); go(0);
      setop(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1, 1, 1); go(0);
      // R8 Z in short with wrap, C/V cleared despite flags_in
      flags_in = 4'b1111;
      setop(32'h1000_0000, 32'h10, 0, 0, 0, 0, 0, 1); go(0);
      // R7 illegal cases
      idx_mul_b = 4'd15; go(0); idx_mul_b = 4'd5;
      idx_dst = 4'd4; go(0);
      long_mode = 1'b1; go(0);
      idx_dst_lo = 4'd15; go(0); idx_dst_lo = 4'd2;
      long_mode = 1'b0; idx_dst = 4'd1; idx_acc = 4'd15; go(0);
      long_mode = 1'b1; go(0); idx_acc = 4'd3;
      // R10 start while busy
      setop(32'h1234_5678, 32'h8765_4321, 32'd11, 32'd22, 1, 1, 1, 1); go(1);
      setop(32'h0000_0ABC, 32'h00F0_0001, 32'd5, 0, 0, 0, 1, 0); go(1);

      for (int i = 0; i < 200; i++) begin
         setop($urandom, $urandom, $urandom, $urandom, 1'($urandom), 1'($urandom),
               1'($urandom), 1'($urandom));
         case ($urandom % 4)
            0: op_b = op_b >> 24;
            1: op_b = 32'($signed(op_b) >>> 16);
            default: ;
         endcase
         flags_in  = 4'($urandom);
         idx_dst   = 4'($urandom % 15);
         idx_dst_lo = 4'($urandom % 15);
         idx_acc   = 4'($urandom % 15);
         idx_mul_a = 4'($urandom % 15);
         idx_mul_b = 4'($urandom % 15);
         if ($urandom % 10 == 0) idx_mul_a = 4'd15;
         go(($urandom % 8) == 0);
      end
      finish_run();
   end
endmodule